// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a two-wire serial slave that gives an external host read and write access to a byte-wide register file held inside the block. A fast system clock oversamples the serial clock and data lines. Each line passes through a synchronizer and a short majority-free glitch filter before the edge and condition detectors. The block recognises START, repeated START and STOP, compares the first byte against its 7-bit device address, and latches the second byte as a register pointer. After that it either stores incoming data bytes or returns register contents. It pulls the data line low through an open-drain enable, `sda_oe_o`. The board or the bench forms the wired-AND bus.

A single select pin moves the device address between two neighbouring values, so two of these slaves can share one bus. In a burst, the pointer advances by two after each byte rather than by one, and it wraps within the 8-bit pointer space. Every internal register write also appears for one cycle on a strobe port. The integrating logic or a testbench can therefore follow what the host writes.

Top module: `twi_reg_slave`

## Requirements
- R1: The device address is 7'b0011010 with `addr_sel_i` low and 7'b0011011 with it high; an address byte (MSB first, address in bits 7..1) whose upper seven bits match is acknowledged by SDA held low through the 9th SCL pulse.
- R2: An address byte that does not match is not acknowledged; SDA is never driven and no register is written until the next START or STOP.
- R3: After a matching address with bit 0 = 0 (write) and an acknowledged register-pointer byte, every following data byte is acknowledged and stored at the pointer; each store emits a one-cycle `wr_stb_o` with `wr_addr_o`/`wr_data_o`, only while SCL is low.
- R4: Consecutive data bytes of one write without START or STOP in between go to pointer, pointer+2, pointer+4, ... computed modulo 256.
- R5: A write-direction address plus pointer byte, followed by a repeated START or by STOP then START, then the address with bit 0 = 1 (read), makes the slave return the register at the pointer, MSB first.
- R6: An acknowledge (SDA = 0) from the master after a read byte makes the slave send the register at pointer+2, wrapping modulo 256.
- R7: A not-acknowledge (SDA = 1) from the master after a read byte releases SDA; further SCL pulses before the next START or STOP see no drive.
- R8: A START or STOP inside a byte aborts it at once: a partial data byte is not stored, and a START begins a fresh address byte.
- R9: Pulses on SCL or SDA shorter than two system clocks do not disturb a transfer.
- R10: Transfers work with a 100 kHz and with a 400 kHz SCL at a 100 MHz system clock.
- R11: After reset SDA is released, no strobe is issued and every register reads as 0x00.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Selects the device address LSB |
| sda_oe_o | output | 1 | High pulls the data line low |
| wr_stb_o | output | 1 | One-cycle pulse per internal register write |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 8 | Data of the write |

## Verification
The bench goes after pointer wrap in both directions. It starts bursts at 0xFE, where a slave that stepped by one, or that saturated, would write or return the wrong register. Aborts in the middle of a byte are driven with STOP and with START. A slave that finishes the byte anyway would store a truncated value or misread the next address. Single-cycle glitches on SCL and SDA are injected inside a data byte; without filtering they would shift in an extra bit or fake a START or STOP. The bench also checks that the slave stays silent after a wrong address and after a master NAK. A slave that kept tracking the bus there would pull SDA low and corrupt another device's traffic.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } twi_state_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // level only moves once FILT_LEN samples agree
      if (&hist_q)       line_q <= 1'b1;
      else if (~|hist_q) line_q <= 1'b0;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      scl_rise_o <= 1'b0;
      scl_fall_o <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      scl_rise_o <= scl_i & ~scl_q;
      scl_fall_o <= ~scl_i & scl_q;
      start_o    <= scl_i & scl_q & sda_q & ~sda_i;
      stop_o     <= scl_i & scl_q & ~sda_q & sda_i;
    end
  end
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << DW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
  import twi_pkg::*;
#(
  parameter int          DW            = 8,
  parameter logic [6:0]  DEV_ADDR_BASE = 7'h1A,
  parameter int          PTR_STEP      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic          addr_sel_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] rd_addr_o,
  output logic          wr_stb_o,
  output logic [DW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sda_oe_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BYTE_END = CW'(DW);
  localparam logic [DW-1:0] STEP = DW'(PTR_STEP);

  twi_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rx_q, tx_q, ptr_q;
  logic          rw_q, mack_q;
  logic [6:0]    dev_addr;

  assign dev_addr  = {DEV_ADDR_BASE[6:1], addr_sel_i};
  assign rd_addr_o = (state_q == ST_RACK) ? ptr_q + STEP : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b1;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (start_i) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_REG, ST_WDATA: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == BYTE_END) begin
              cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (rx_q[DW-1:1] == dev_addr) begin
                  rw_q    <= rx_q[0];
                  state_q <= ST_DEV_ACK;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (state_q == ST_REG) begin
                ptr_q   <= rx_q;
                state_q <= ST_REG_ACK;
              end else begin
                wr_stb_o  <= 1'b1;
                wr_addr_o <= ptr_q;
                wr_data_o <= rx_q;
                ptr_q     <= ptr_q + STEP;
                state_q   <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                tx_q    <= rd_data_i;
                cnt_q   <= '0;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_REG;
              end
            end
          end
          ST_REG_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == BYTE_END) begin
                cnt_q   <= '0;
                state_q <= ST_RACK;
              end else begin
                tx_q <= {tx_q[DW-2:0], 1'b1};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (!mack_q) begin
                ptr_q   <= ptr_q + STEP;
                tx_q    <= rd_data_i;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_DEV_ACK, ST_REG_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
      ST_RDATA:                             sda_oe_o = ~tx_q[DW-1];
      default:                              sda_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0] DEV_ADDR_BASE = 7'h1A,
  parameter int         SYNC_STAGES   = 2,
  parameter int         FILT_LEN      = 2,
  parameter int         PTR_STEP      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  localparam int DW     = 8;
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_rise, scl_fall, ev_start, ev_stop;
  logic [DW-1:0] rd_addr, rd_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    twi_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  twi_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt_lines[0]),
    .sda_i     (filt_lines[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (ev_start),
    .stop_o    (ev_stop)
  );

  twi_slave_ctrl #(
    .DW           (DW),
    .DEV_ADDR_BASE(DEV_ADDR_BASE),
    .PTR_STEP     (PTR_STEP)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (ev_start),
    .stop_i    (ev_stop),
    .sda_i     (filt_lines[1]),
    .addr_sel_i(addr_sel_i),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .sda_oe_o  (sda_oe_o)
  );

  twi_regfile #(.DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_stb_o),
    .waddr_i(wr_addr_o),
    .wdata_i(wr_data_o),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       wr_stb_o,
  input logic [7:0] wr_addr_o,
  input logic       start_i,
  input logic       stop_i
);
  logic       have_last_q;
  logic [7:0] last_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_last_q <= 1'b0;
      last_addr_q <= '0;
    end else if (start_i || stop_i) begin
      have_last_q <= 1'b0;
    end else if (wr_stb_o) begin
      have_last_q <= 1'b1;
      last_addr_q <= wr_addr_o;
    end
  end

  AST_OE_CHANGE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i); // R12
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R3
  AST_STB_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !scl_i); // R3
  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && have_last_q) |-> (wr_addr_o == 8'(last_addr_q + 8'd2))); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R8
  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_o); // R8
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .wr_stb_o (wr_stb_o),
  .wr_addr_o(wr_addr_o),
  .start_i  (ev_start),
  .stop_i   (ev_stop)
);

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;
  localparam int Q_FAST = 63;
  localparam int Q_STD  = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, wr_stb;
  logic [7:0] wr_addr, wr_data;
  logic sda_bus;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twi_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int tests = 0, fails = 0, q = Q_FAST;
  int stb_cnt = 0;
  logic [7:0] last_wa, last_wd;
  bit oe_seen = 0, done = 0;
  logic [7:0] shadow [256];
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  always @(posedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cnt++;
      last_wa = wr_addr;
      last_wd = wr_data;
    end
    if (sda_oe) oe_seen = 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input bit sel, input bit rd);
    return {6'b001101, sel, rd};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b, input bit glitch, output bit smp);
    sda_m = b; wait_cyc(q);
    scl_m = 1; wait_cyc(q / 2);
    if (glitch) begin
      scl_m = 0; wait_cyc(1); scl_m = 1; wait_cyc(2);
      sda_m = ~b; wait_cyc(1); sda_m = b;
    end
    wait_cyc(q / 2);
    smp = sda_bus; wait_cyc(q);
    scl_m = 0; wait_cyc(q);
  endtask

  task automatic bus_start();
    sda_m = 1; wait_cyc(q); scl_m = 1; wait_cyc(q);
    sda_m = 0; wait_cyc(q); scl_m = 0; wait_cyc(q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wait_cyc(q); scl_m = 1; wait_cyc(q); sda_m = 1; wait_cyc(q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gbit, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], i == gbit, s);
    clk_bit(1'b1, 1'b0, ack);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clk_bit(mack, 1'b0, s);
  endtask

  task automatic write_txn(input bit sel, input logic [7:0] ra, input int n,
                           input int gbit, output logic [7:0] nacks);
    bit a;
    logic [7:0] p = ra;
    nacks = 0;
    bus_start();
    send_byte(dev_byte(sel, 1'b0), -1, a); nacks += 8'(a);
    send_byte(ra, -1, a); nacks += 8'(a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], gbit, a); nacks += 8'(a);
      shadow[p] = wbuf[i];
      p = p + 8'd2;
    end
    bus_stop();
  endtask

  task automatic read_txn(input bit sel, input logic [7:0] ra, input int n,
                          input bit use_stop, input bit keep_bus, output logic [7:0] nacks);
    bit a;
    nacks = 0;
    bus_start();
    send_byte(dev_byte(sel, 1'b0), -1, a); nacks += 8'(a);
    send_byte(ra, -1, a); nacks += 8'(a);
    if (use_stop) bus_stop();
    bus_start();
    send_byte(dev_byte(sel, 1'b1), -1, a); nacks += 8'(a);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    if (!keep_bus) bus_stop();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] nk, b, ra, d0, d1;
    bit a;
    int sc;
    void'($urandom(32'h5EED_2C1A));
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    wait_cyc(5);
    chk(sda_oe == 0 && wr_stb == 0, "R11 reset outputs", {sda_oe, wr_stb}, 0);
    rst_n = 1;
    wait_cyc(5);

    // R1 R3 write with select low
    wbuf[0] = 8'hA5;
    write_txn(0, 8'h10, 1, -1, nk);
    chk(nk == 0, "R1 R3 write acks", nk, 0);
    chk(last_wa == 8'h10 && last_wd == 8'hA5, "R3 strobe addr/data", {last_wa, last_wd}, 16'h10A5);

    // R5 read via repeated START, and R11 unwritten register reads zero
    read_txn(0, 8'h10, 1, 0, 0, nk);
    chk(nk == 0 && rbuf[0] == 8'hA5, "R5 read rstart", rbuf[0], 8'hA5);
    read_txn(0, 8'h11, 1, 1, 0, nk);
    chk(nk == 0 && rbuf[0] == 8'h00, "R11 reset register value", rbuf[0], 0);

    // R4 burst write across wrap
    sc = stb_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_txn(0, 8'hFE, 3, -1, nk);
    chk(nk == 0 && stb_cnt == sc + 3, "R4 burst strobes", stb_cnt - sc, 3);
    chk(last_wa == 8'h02 && last_wd == 8'h33, "R4 wrap step", last_wa, 8'h02);

    // R6 burst read across wrap via STOP+START, then R7 after NAK
    read_txn(0, 8'hFE, 3, 1, 1, nk);
    chk(nk == 0, "R5 read acks", nk, 0);
    chk(rbuf[0] == shadow[8'hFE], "R6 first byte", rbuf[0], shadow[8'hFE]);
    chk(rbuf[1] == shadow[8'h00], "R6 wrap byte", rbuf[1], shadow[8'h00]);
    chk(rbuf[2] == shadow[8'h02], "R6 third byte", rbuf[2], shadow[8'h02]);
    oe_seen = 0;
    recv_byte(1, b);
    chk(b == 8'hFF && !oe_seen, "R7 released after NAK", b, 8'hFF);
    bus_stop();

    // R2 wrong address: no ack and no drive
    sc = stb_cnt;
    oe_seen = 0;
    bus_start();
    send_byte(dev_byte(1, 0), -1, a);
    chk(a == 1, "R2 mismatch nak", a, 1);
    send_byte(8'h00, -1, a);
    send_byte(8'h5A, -1, a);
    bus_stop();
    chk(!oe_seen && stb_cnt == sc, "R2 silent", {oe_seen, 8'(stb_cnt - sc)}, 0);

    // R1 R10 select high at standard rate
    q = Q_STD;
    addr_sel = 1;
    wbuf[0] = 8'h3C;
    write_txn(1, 8'h20, 1, -1, nk);
    chk(nk == 0 && last_wa == 8'h20 && last_wd == 8'h3C, "R1 R10 std rate write", last_wd, 8'h3C);
    q = Q_FAST;
    read_txn(1, 8'h20, 1, 0, 0, nk);
    chk(nk == 0 && rbuf[0] == 8'h3C, "R10 fast readback", rbuf[0], 8'h3C);

    // R8 STOP inside a data byte
    sc = stb_cnt;
    bus_start();
    send_byte(dev_byte(1, 0), -1, a);
    send_byte(8'h30, -1, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, a);
    bus_stop();
    chk(stb_cnt == sc, "R8 stop abort no write", stb_cnt - sc, 0);
    // R8 START inside the address byte
    bus_start();
    for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, a);
    wbuf[0] = 8'h77;
    write_txn(1, 8'h32, 1, -1, nk);
    chk(nk == 0 && last_wa == 8'h32 && last_wd == 8'h77, "R8 start restart", last_wd, 8'h77);
    read_txn(1, 8'h30, 2, 0, 0, nk);
    chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h77, "R8 partial not stored", {rbuf[0], rbuf[1]}, 16'h0077);

    // R9 glitches inside a data byte
    wbuf[0] = 8'h5A;
    write_txn(1, 8'h40, 1, 4, nk);
    chk(nk == 0 && last_wa == 8'h40 && last_wd == 8'h5A, "R9 glitch write", last_wd, 8'h5A);
    read_txn(1, 8'h40, 1, 1, 0, nk);
    chk(rbuf[0] == 8'h5A, "R9 glitch readback", rbuf[0], 8'h5A);

    // random bursts
    for (int t = 0; t < 2; t++) begin
      ra = 8'($urandom); d0 = 8'($urandom); d1 = 8'($urandom);
      wbuf[0] = d0; wbuf[1] = d1;
      write_txn(1, ra, 2, -1, nk);
      chk(nk == 0, "R3 random acks", nk, 0);
      read_txn(1, ra, 2, t[0], 0, nk);
      chk(rbuf[0] == shadow[ra] && rbuf[1] == shadow[8'(ra + 8'd2)], "R6 random burst",
          {rbuf[0], rbuf[1]}, {shadow[ra], shadow[8'(ra + 8'd2)]});
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule